// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block reproduces the status behaviour of one bank of a parallel NOR flash while an internal program or erase runs. It does not model the cell array or decode command sequences. A single strobe stands for the last write pulse of a program, erase, suspend or resume sequence. The block holds one byte of "last written" data. That byte is what a read returns once the bank is back in read mode.

While an operation is active, a read returns a status byte. Bit 7 is a polling bit: it is the inverse of the data bit being programmed, or 0 while an erase runs. Bit 5 is a sticky timeout flag. The other bits read 0. A registered ready output is low while the bank is busy.

An operation aimed at a protected sector only holds the bank busy for a short window and changes no data. Erase can be suspended. A program may run inside the suspension, and the erase can then be resumed.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, ready is 1, rd_valid is 0 and rd_data is 0. The stored data byte is 8'hFF, and the first read returns it.
- R2: A program start taken in read mode holds ready low for exactly PROG_CYC cycles, counted from the clock edge that samples the strobe.
- R3: A status read during a program returns bit 7 = inverse of bit 7 of the programmed byte, bit 5 = timeout flag, and all other bits 0.
- R4: After a program ends, the first read in read mode returns bit 7 of the stored byte with bits 6..0 still in status form (bit 5 = flag, others 0). Later reads return the whole stored byte, which is the programmed byte.
- R5: An erase start holds ready low for ERASE_CYC cycles, and status reads during it return bit 7 = 0. On completion the stored byte becomes 8'hFF, with the same one-read lag as R4.
- R6: A suspend strobe during an unprotected erase sets ready high on the next cycle, and status reads return bit 7 = 1. After a resume strobe, ready stays low for exactly the erase cycles that were left.
- R7: A program started while an erase is suspended follows R3 and lasts PROG_CYC cycles. The bank then goes back to the suspended state, not to read mode.
- R8: A program aimed at a protected sector holds ready low for PPROT_CYC cycles with the R3 status, and leaves the stored byte unchanged.
- R9: An erase aimed at a protected sector holds ready low for EPROT_CYC cycles with bit 7 = 0, and leaves the stored byte unchanged.
- R10: Bit 5 becomes 1 once a running operation's elapsed cycle count reaches TMO_LIMIT. It stays 1 across later operations until a reset command strobe.
- R11: The block ignores these strobes: program or erase starts while busy, suspend outside an unprotected erase, resume outside suspension, and erase start during suspension.
- R12: Each read strobe gives exactly one rd_valid pulse, with rd_data, on the next cycle. No read strobe means no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_go | input | 1 | Program start strobe (final write of the sequence) |
| erase_go | input | 1 | Erase start strobe |
| suspend_go | input | 1 | Erase suspend strobe |
| resume_go | input | 1 | Erase resume strobe |
| reset_cmd | input | 1 | Reset command strobe, clears the timeout flag |
| cmd_data | input | DW | Byte to program |
| sect_prot | input | 1 | Target sector is protected, sampled with a start strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Read result, registered |
| rd_valid | output | 1 | rd_data is valid this cycle |
| ready | output | 1 | High when the bank is not busy |

## Verification
A start strobe is sampled on edge E0. Ready falls right after E0 and rises right after edge EN, where N is the window length. The bench therefore counts the low-ready cycles it sees at falling edges and compares the count with N. A read strobe is sampled on one edge and its byte is due just after that edge, so each read is checked at the next falling edge. The resume count is N minus the running edges already taken before suspension, including the edge that sampled the suspend strobe. The bench sweeps all 256 program bytes through the R3 and R4 checks. It then runs the protected, suspended, timeout and ignored-strobe sequences with a reference byte and flag that it keeps itself.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_PBUSY = 2'd1,
    ST_EBUSY = 2'd2,
    ST_SUSP  = 2'd3
  } fsg_state_e;
endpackage

// File: rtl/fsg_timer.sv
`timescale 1ns/1ps
module fsg_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic          done,
  output logic [CW-1:0] el
);
  logic [CW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      el    <= '0;
      len_q <= '0;
    end else if (start) begin
      el    <= '0;
      len_q <= len;
    end else if (run) begin
      el <= el + 1'b1;
    end
  end

  assign done = run && (el == len_q - 1'b1);

  // R2: a running window never counts past its length
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    run |-> (el < len_q));
endmodule

// File: rtl/fsg_ctrl.sv
`timescale 1ns/1ps
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 17,
  parameter int PROG_CYC  = 2000,
  parameter int ERASE_CYC = 60000,
  parameter int PPROT_CYC = 200,
  parameter int EPROT_CYC = 20000,
  parameter int TMO_LIMIT = 50000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_go,
  input  logic          erase_go,
  input  logic          suspend_go,
  input  logic          resume_go,
  input  logic          reset_cmd,
  input  logic [DW-1:0] cmd_data,
  input  logic          sect_prot,
  output fsg_state_e    state,
  output logic [DW-1:0] pdata,
  output logic [DW-1:0] data_q,
  output logic          flag,
  output logic          op_end,
  output logic          ready
);
  localparam logic [CW-1:0] L_PROG  = CW'(PROG_CYC);
  localparam logic [CW-1:0] L_ERASE = CW'(ERASE_CYC);
  localparam logic [CW-1:0] L_PPROT = CW'(PPROT_CYC);
  localparam logic [CW-1:0] L_EPROT = CW'(EPROT_CYC);
  localparam logic [CW-1:0] L_TMO   = CW'(TMO_LIMIT);

  fsg_state_e    state_n;
  logic          p_start, e_start, p_run, e_run, p_done, e_done;
  logic [CW-1:0] p_el, e_el, p_len, e_len;
  logic          p_prot, p_in_susp, e_prot;

  assign p_start = prog_go && (state == ST_READ || state == ST_SUSP);
  assign e_start = erase_go && !prog_go && (state == ST_READ);
  assign p_run   = (state == ST_PBUSY);
  assign e_run   = (state == ST_EBUSY);
  assign p_len   = sect_prot ? L_PPROT : L_PROG;
  assign e_len   = sect_prot ? L_EPROT : L_ERASE;

  fsg_timer #(.CW(CW)) i_ptimer (
    .clk(clk), .rst(rst), .start(p_start), .run(p_run),
    .len(p_len), .done(p_done), .el(p_el));

  fsg_timer #(.CW(CW)) i_etimer (
    .clk(clk), .rst(rst), .start(e_start), .run(e_run),
    .len(e_len), .done(e_done), .el(e_el));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_READ: begin
        if (p_start)      state_n = ST_PBUSY;
        else if (e_start) state_n = ST_EBUSY;
      end
      ST_PBUSY: begin
        if (p_done) state_n = p_in_susp ? ST_SUSP : ST_READ;
      end
      ST_EBUSY: begin
        if (e_done)                     state_n = ST_READ;
        else if (suspend_go && !e_prot) state_n = ST_SUSP;
      end
      ST_SUSP: begin
        if (p_start)        state_n = ST_PBUSY;
        else if (resume_go) state_n = ST_EBUSY;
      end
      default: state_n = ST_READ;
    endcase
  end

  assign op_end = (state_n == ST_READ) && (state != ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_READ;
      pdata     <= '0;
      p_prot    <= 1'b0;
      p_in_susp <= 1'b0;
      e_prot    <= 1'b0;
      data_q    <= '1;
      flag      <= 1'b0;
      ready     <= 1'b1;
    end else begin
      state <= state_n;
      ready <= (state_n == ST_READ) || (state_n == ST_SUSP);
      if (p_start) begin
        pdata     <= cmd_data;
        p_prot    <= sect_prot;
        p_in_susp <= (state == ST_SUSP);
      end
      if (e_start) e_prot <= sect_prot;
      if (p_done && !p_prot)      data_q <= pdata;
      else if (e_done && !e_prot) data_q <= '1;
      if (reset_cmd) flag <= 1'b0;
      else if ((p_run && p_el == L_TMO) || (e_run && e_el == L_TMO)) flag <= 1'b1;
    end
  end

  // R10: the timeout flag holds until a reset command
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !reset_cmd) |=> flag);
  // R6: a suspended erase keeps its elapsed count
  a_r6_susp_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP) |=> $stable(e_el));
  // R8: a protected program never alters the stored byte
  a_r8_prot_keeps: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PBUSY && p_prot) |=> $stable(data_q));
  // R11: a running program is not restarted by new strobes
  a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PBUSY && !p_done) |=> (state == ST_PBUSY && $stable(pdata)));
endmodule

// File: rtl/fsg_rdout.sv
`timescale 1ns/1ps
module fsg_rdout
  import fsg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  fsg_state_e    state,
  input  logic [DW-1:0] pdata,
  input  logic [DW-1:0] data_q,
  input  logic          flag,
  input  logic          op_end,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int MSB      = DW - 1;
  localparam int FLAG_BIT = 5;

  logic          lag;
  logic [DW-1:0] stat, rd_next;

  always_comb begin
    stat           = '0;
    stat[FLAG_BIT] = flag;
    unique case (state)
      ST_PBUSY: stat[MSB] = ~pdata[MSB];
      ST_EBUSY: stat[MSB] = 1'b0;
      ST_SUSP:  stat[MSB] = 1'b1;
      default:  stat[MSB] = data_q[MSB];
    endcase
    rd_next = (state == ST_READ && !lag) ? data_q : stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lag      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
      if (op_end)                             lag <= 1'b1;
      else if (rd_en && state == ST_READ)     lag <= 1'b0;
    end
  end

  // R12: one valid pulse per read strobe
  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R5: erase status polls low
  a_r5_erase_low: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_EBUSY) |=> !rd_data[MSB]);
  // R3: program status polls the inverted data bit
  a_r3_prog_inv: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_PBUSY) |=> (rd_data[MSB] == !$past(pdata[MSB])));
endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 17,
  parameter int PROG_CYC  = 2000,
  parameter int ERASE_CYC = 60000,
  parameter int PPROT_CYC = 200,
  parameter int EPROT_CYC = 20000,
  parameter int TMO_LIMIT = 50000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_go,
  input  logic          erase_go,
  input  logic          suspend_go,
  input  logic          resume_go,
  input  logic          reset_cmd,
  input  logic [DW-1:0] cmd_data,
  input  logic          sect_prot,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ready
);
  fsg_state_e    state;
  logic [DW-1:0] pdata, data_q;
  logic          flag, op_end;

  fsg_ctrl #(
    .DW(DW), .CW(CW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .PPROT_CYC(PPROT_CYC), .EPROT_CYC(EPROT_CYC), .TMO_LIMIT(TMO_LIMIT)
  ) i_ctrl (
    .clk(clk), .rst(rst), .prog_go(prog_go), .erase_go(erase_go),
    .suspend_go(suspend_go), .resume_go(resume_go), .reset_cmd(reset_cmd),
    .cmd_data(cmd_data), .sect_prot(sect_prot), .state(state),
    .pdata(pdata), .data_q(data_q), .flag(flag), .op_end(op_end),
    .ready(ready));

  fsg_rdout #(.DW(DW)) i_rdout (
    .clk(clk), .rst(rst), .rd_en(rd_en), .state(state), .pdata(pdata),
    .data_q(data_q), .flag(flag), .op_end(op_end),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // R2: ready is low in every busy state
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PBUSY || state == ST_EBUSY) |-> !ready);
endmodule

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
  localparam int DW = 8, CW = 8, PROG = 12, ERASE = 30, PPROT = 4, EPROT = 9, TMO = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic prog_go = 0, erase_go = 0, suspend_go = 0, resume_go = 0, reset_cmd = 0;
  logic [DW-1:0] cmd_data = '0;
  logic sect_prot = 0, rd_en = 0;
  logic [DW-1:0] rd_data;
  logic rd_valid, ready;

  always #2.5 clk = ~clk;

  flash_status_gen #(
    .DW(DW), .CW(CW), .PROG_CYC(PROG), .ERASE_CYC(ERASE),
    .PPROT_CYC(PPROT), .EPROT_CYC(EPROT), .TMO_LIMIT(TMO)
  ) i_flash_status_gen (
    .clk(clk), .rst(rst), .prog_go(prog_go), .erase_go(erase_go),
    .suspend_go(suspend_go), .resume_go(resume_go), .reset_cmd(reset_cmd),
    .cmd_data(cmd_data), .sect_prot(sect_prot), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready));

  int n_run = 0, n_fail = 0;
  logic [7:0] mem;
  logic flg;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input logic msb, input logic f);
    return {msb, 1'b0, f, 5'b0};
  endfunction

  task automatic rd(output logic [7:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    chk("R12 valid", rd_valid, 1);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_prog(input logic [7:0] d, input bit prot, input bit insusp, input string tag);
    logic [7:0] v;
    int n;
    cmd_data = d; sect_prot = prot; prog_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0; sect_prot = 1'b0;
    chk("R2 ready low", ready, 0);
    rd(v); chk(tag, v, st(~d[7], flg));
    wait_ready(n);
    chk(prot ? "R8 window" : "R2 duration", n + 1, prot ? PPROT : PROG);
    if (!prot) mem = d;
    if (insusp) begin
      rd(v); chk("R7 back in suspend", v, st(1'b1, flg));
    end else begin
      rd(v); chk("R4 lag read", v, st(mem[7], flg));
      rd(v); chk(prot ? "R8 data kept" : "R4 data", v, mem);
    end
  endtask

  task automatic do_erase(input bit prot);
    logic [7:0] v;
    int n;
    sect_prot = prot; erase_go = 1'b1;
    @(negedge clk);
    erase_go = 1'b0; sect_prot = 1'b0;
    chk("R5 ready low", ready, 0);
    rd(v); chk(prot ? "R9 status" : "R5 status", v, st(1'b0, flg));
    wait_ready(n);
    chk(prot ? "R9 window" : "R5 duration", n + 1, prot ? EPROT : ERASE);
    if (!prot) begin mem = 8'hFF; flg = 1'b1; end
    rd(v); chk("R5 lag read", v, st(mem[7], flg));
    rd(v); chk(prot ? "R9 data kept" : "R5 erased", v, mem);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 valid", rd_valid, 0);
    chk("R1 data", rd_data, 0);
    rst = 1'b0;
    mem = 8'hFF; flg = 1'b0;
    rd(v); chk("R1 first read", v, 8'hFF);

    // sweep every program byte through the polling and lag rules
    for (int d = 0; d < 256; d++) do_prog(8'(d), 1'b0, 1'b0, "R3 status");

    do_prog(8'h5A, 1'b0, 1'b0, "R3 status");
    do_prog(8'hA5, 1'b1, 1'b0, "R8 status");

    // erase runs long enough to raise the timeout flag
    do_erase(1'b0);
    do_prog(8'h12, 1'b0, 1'b0, "R10 flag persists");
    reset_cmd = 1'b1; @(negedge clk); reset_cmd = 1'b0; flg = 1'b0;
    do_prog(8'h34, 1'b0, 1'b0, "R10 flag cleared");

    do_erase(1'b1);

    // suspend, program inside, ignored erase, resume
    erase_go = 1'b1; @(negedge clk); erase_go = 1'b0;
    repeat (4) @(negedge clk);
    suspend_go = 1'b1; @(negedge clk); suspend_go = 1'b0;
    chk("R6 ready in suspend", ready, 1);
    rd(v); chk("R6 suspend status", v, st(1'b1, flg));
    do_prog(8'h7F, 1'b0, 1'b1, "R7 status");
    erase_go = 1'b1; @(negedge clk); erase_go = 1'b0;
    chk("R11 erase in suspend", ready, 1);
    rd(v); chk("R11 still suspended", v, st(1'b1, flg));
    resume_go = 1'b1; @(negedge clk); resume_go = 1'b0;
    chk("R6 resumed busy", ready, 0);
    wait_ready(n);
    chk("R6 remaining", n, ERASE - 5);
    mem = 8'hFF; flg = 1'b1;
    rd(v); chk("R6 lag read", v, st(1'b1, flg));
    rd(v); chk("R6 erased", v, mem);

    // strobes while busy are ignored
    cmd_data = 8'h55; prog_go = 1'b1; @(negedge clk); prog_go = 1'b0;
    rd(v); chk("R3 status", v, st(1'b1, flg));
    cmd_data = 8'hAA; prog_go = 1'b1; erase_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0; erase_go = 1'b0;
    wait_ready(n);
    chk("R11 duration", n + 2, PROG);
    mem = 8'h55;
    rd(v); chk("R11 lag read", v, st(1'b0, flg));
    rd(v); chk("R11 data", v, mem);
    suspend_go = 1'b1; @(negedge clk); suspend_go = 1'b0;
    chk("R11 suspend in read", ready, 1);
    resume_go = 1'b1; @(negedge clk); resume_go = 1'b0;
    chk("R11 resume in read", ready, 1);
    rd(v); chk("R11 data after", v, mem);
    @(negedge clk);
    chk("R12 no spurious valid", rd_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule